// File: doc/BRIEF.md
# Two-Stage Programmable Address Decoder

This block turns a 32-bit processor address into a decision about which part of the system should answer it. The first stage picks one of eight regions: four 32 MB expansion-device spaces, one 128 MB DRAM space, one 128 MB simple-I/O space, one 256 MB card space and one 64 MB internal register space. It does this by comparing the high-order address bits against a programmable base register for each region. Each base register also carries an enable bit, so a disabled region never claims an address.

The second stage works inside the chosen region and produces a bank or chip-select index. DRAM banks and expansion-device banks are located by programmable low/high bounds on a field of address bits. Banks of different sizes can therefore be packed into one contiguous span. The card, simple-I/O and internal-register regions use fixed sub-decodes.

An address that lands in no region gives no hit, so the system does not respond to it. A small write port loads the base, bound and mode registers. The decision is combinational and is registered once at the output when the `REG_OUT` parameter is set (default 1).

Top module: `twostage_addr_decoder`

## Requirements
- R1: `region_sel` is zero or one-hot. Bit r is set only when region r is enabled and `addr` lies in its aligned window. That window is 32 MB for r=0..3, 128 MB for r=4 (DRAM), 128 MB for r=5 (simple-I/O), 256 MB for r=6 (card) and 64 MB for r=7 (internal registers), starting at address {base,25'b0}. When enabled windows overlap, the lowest r wins.
- R2: Write-port index r in 0..7 sets region r as follows: `wr_data[7]` is the enable and `wr_data[6:0]` is the base, meaning address bits 31:25. After reset every region is disabled.
- R3: In the DRAM region, bank b (indices 8..11, low in `wr_data[5:0]`, high in `wr_data[13:8]`) matches when low <= `addr[25:20]` <= high. The lowest matching bank is reported. After reset every bank has low=63 and high=0, so it is empty.
- R4: In any of the four expansion regions, bank b (indices 12..15, low in `wr_data[3:0]`, high in `wr_data[11:8]`) matches when low <= `addr[24:21]` <= high. The lowest matching bank is reported. After reset every bank has low=15 and high=0.
- R5: The card region always hits. The index is 0 for card A memory, 1 for card A I/O, 2 for card B memory and 3 for card B I/O. These are the 64 MB quarters of the region in ascending address order, so the index equals `addr[27:26]`.
- R6: In the simple-I/O region in four-select mode, the index is `addr[25:24]` when `addr[26]`=0. The upper 64 MB of the region gives no hit.
- R7: Writing index 16 with `wr_data[0]`=1 selects eight-select mode. In that mode the whole simple-I/O region hits, with index `addr[26:24]`. After reset the mode is four-select.
- R8: The internal register region hits only in its lowest 4 KB, where `addr[25:12]`=0. The index there is `addr[11:10]`.
- R9: When no region matches, `region_sel`=0, `hit`=0 and `bank_idx`=0.
- R10: When a region matches but no bank or select inside it does, `region_sel` shows the region, `hit`=0 and `bank_idx`=0.
- R11: The outputs show the decode of the `addr` value present at the previous rising clock edge. All outputs are zero during reset.
- R12: A write takes effect for decodes from the next clock edge onward. Writes to indices 17..31 change no decode result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 32 | Address to decode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register index |
| wr_data | input | 16 | Register write value |
| region_sel | output | 8 | One-hot region select |
| bank_idx | output | 3 | Bank or chip-select index inside the region |
| hit | output | 1 | Address is claimed by a bank or select |

## Verification
The bench targets overlapping region windows. A design with the wrong priority would select two regions, or the higher one. It also programs DRAM banks whose bounds overlap. There a wrong priority reports bank 3 instead of bank 0, and a design that tests bounds as exclusive loses the single-slot 1 MB bank. The simple-I/O upper half in four-select mode and the area just above the 4 KB register window must give no hit; a design that skips those limits would claim addresses nothing answers. Writes to unused indices, the one-cycle output latency and region-hit-without-bank cases are covered as well, and they are mixed with randomly placed addresses and randomly reprogrammed bounds.

// File: rtl/addrdec_pkg.sv
package addrdec_pkg;
  localparam int NUM_REGIONS = 8;
  localparam int IDX_W       = 3;

  typedef enum logic [2:0] {
    RG_EXP0, RG_EXP1, RG_EXP2, RG_EXP3, RG_DRAM, RG_SIO, RG_CARD, RG_CSR
  } region_e;

  // log2 of the window size of each region
  function automatic int unsigned region_lg(input int r);
    case (r)
      4, 5:    return 27;
      6:       return 28;
      7:       return 26;
      default: return 25;
    endcase
  endfunction

  // address lies in the aligned window that starts at {base,25'b0}
  function automatic logic base_match(input logic [31:0] a, input logic [6:0] base,
                                      input int unsigned lg);
    logic [31:0] keep;
    keep = '1;
    keep = keep << lg;
    return ((a ^ {base, 25'd0}) & keep) == 32'd0;
  endfunction

  function automatic logic in_span(input logic [7:0] f, input logic [7:0] lo,
                                   input logic [7:0] hi);
    return (f >= lo) && (f <= hi);
  endfunction

  // keep only the lowest set bit
  function automatic logic [NUM_REGIONS-1:0] lowest_bit(input logic [NUM_REGIONS-1:0] v);
    return v & (~v + 1'b1);
  endfunction
endpackage

// File: rtl/addrdec_regs.sv
module addrdec_regs
  import addrdec_pkg::*;
#(
  parameter int N_DRAM = 4,
  parameter int N_EXP  = 4,
  parameter int REG_AW = 5,
  parameter int DF_W   = 6,
  parameter int EF_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [REG_AW-1:0]            wr_addr,
  input  logic [15:0]                  wr_data,
  output logic [NUM_REGIONS-1:0]       space_en,
  output logic [NUM_REGIONS-1:0][6:0]  space_base,
  output logic [N_DRAM-1:0][DF_W-1:0]  dram_lo,
  output logic [N_DRAM-1:0][DF_W-1:0]  dram_hi,
  output logic [N_EXP-1:0][EF_W-1:0]   exp_lo,
  output logic [N_EXP-1:0][EF_W-1:0]   exp_hi,
  output logic                         sio_eight
);
  localparam int DRAM_IX = NUM_REGIONS;
  localparam int EXP_IX  = DRAM_IX + N_DRAM;
  localparam int MODE_IX = EXP_IX + N_EXP;

  logic unused_data;
  assign unused_data = ^wr_data[15:14];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      space_en   <= '0;
      space_base <= '0;
      dram_lo    <= '1;
      dram_hi    <= '0;
      exp_lo     <= '1;
      exp_hi     <= '0;
      sio_eight  <= 1'b0;
    end else if (wr_en) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (wr_addr == REG_AW'(r)) begin
          space_en[r]   <= wr_data[7];
          space_base[r] <= wr_data[6:0];
        end
      end
      for (int b = 0; b < N_DRAM; b++) begin
        if (wr_addr == REG_AW'(DRAM_IX + b)) begin
          dram_lo[b] <= wr_data[DF_W-1:0];
          dram_hi[b] <= wr_data[8+DF_W-1:8];
        end
      end
      for (int b = 0; b < N_EXP; b++) begin
        if (wr_addr == REG_AW'(EXP_IX + b)) begin
          exp_lo[b] <= wr_data[EF_W-1:0];
          exp_hi[b] <= wr_data[8+EF_W-1:8];
        end
      end
      if (wr_addr == REG_AW'(MODE_IX)) sio_eight <= wr_data[0];
    end
  end
endmodule

// File: rtl/addrdec_space.sv
module addrdec_space
  import addrdec_pkg::*;
(
  input  logic [31:0]                  addr,
  input  logic [NUM_REGIONS-1:0]       space_en,
  input  logic [NUM_REGIONS-1:0][6:0]  space_base,
  output logic [NUM_REGIONS-1:0]       raw_match,
  output logic [NUM_REGIONS-1:0]       sel
);
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    assign raw_match[r] = space_en[r] && base_match(addr, space_base[r], region_lg(r));
  end
  assign sel = lowest_bit(raw_match);
endmodule

// File: rtl/addrdec_span_pick.sv
module addrdec_span_pick
  import addrdec_pkg::*;
#(
  parameter int N  = 4,
  parameter int W  = 6,
  parameter int IW = 2
) (
  input  logic [W-1:0]        field,
  input  logic [N-1:0][W-1:0] lo,
  input  logic [N-1:0][W-1:0] hi,
  output logic [N-1:0]        match,
  output logic                found,
  output logic [IW-1:0]       idx
);
  for (genvar b = 0; b < N; b++) begin : g_bank
    assign match[b] = in_span(8'(field), 8'(lo[b]), 8'(hi[b]));
  end

  assign found = |match;

  always_comb begin
    idx = '0;
    for (int b = N - 1; b >= 0; b--) begin
      if (match[b]) idx = IW'(b);
    end
  end
endmodule

// File: rtl/twostage_addr_decoder.sv
module twostage_addr_decoder
  import addrdec_pkg::*;
#(
  parameter int N_DRAM     = 4,
  parameter int N_EXP      = 4,
  parameter int REG_AW     = 5,
  parameter int REG_OUT    = 1,
  parameter int CSR_WIN_LG = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       addr,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic [7:0]        region_sel,
  output logic [2:0]        bank_idx,
  output logic              hit
);
  localparam int DF_W = 6;
  localparam int EF_W = 4;
  localparam int DI_W = (N_DRAM > 1) ? $clog2(N_DRAM) : 1;
  localparam int EI_W = (N_EXP > 1) ? $clog2(N_EXP) : 1;

  logic [NUM_REGIONS-1:0]       space_en;
  logic [NUM_REGIONS-1:0][6:0]  space_base;
  logic [N_DRAM-1:0][DF_W-1:0]  dram_lo, dram_hi;
  logic [N_EXP-1:0][EF_W-1:0]   exp_lo, exp_hi;
  logic                         sio_eight;

  logic [NUM_REGIONS-1:0] raw_match, comb_sel;
  logic [N_DRAM-1:0]      dram_match;
  logic [N_EXP-1:0]       exp_match;
  logic                   dram_found, exp_found;
  logic [DI_W-1:0]        dram_idx;
  logic [EI_W-1:0]        exp_idx;
  logic                   comb_hit;
  logic [IDX_W-1:0]       comb_idx;
  logic [2:0]             sio_slot;
  logic                   csr_in_win;

  addrdec_regs #(.N_DRAM(N_DRAM), .N_EXP(N_EXP), .REG_AW(REG_AW), .DF_W(DF_W), .EF_W(EF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .space_en(space_en), .space_base(space_base), .dram_lo(dram_lo), .dram_hi(dram_hi),
    .exp_lo(exp_lo), .exp_hi(exp_hi), .sio_eight(sio_eight)
  );

  addrdec_space u_space (
    .addr(addr), .space_en(space_en), .space_base(space_base),
    .raw_match(raw_match), .sel(comb_sel)
  );

  addrdec_span_pick #(.N(N_DRAM), .W(DF_W), .IW(DI_W)) u_dram (
    .field(addr[25:20]), .lo(dram_lo), .hi(dram_hi),
    .match(dram_match), .found(dram_found), .idx(dram_idx)
  );

  addrdec_span_pick #(.N(N_EXP), .W(EF_W), .IW(EI_W)) u_exp (
    .field(addr[24:21]), .lo(exp_lo), .hi(exp_hi),
    .match(exp_match), .found(exp_found), .idx(exp_idx)
  );

  assign sio_slot   = addr[26:24];
  assign csr_in_win = (addr[25:CSR_WIN_LG] == '0);

  always_comb begin
    comb_hit = 1'b0;
    comb_idx = '0;
    if (|comb_sel[RG_EXP3:RG_EXP0]) begin
      comb_hit = exp_found;
      if (exp_found) comb_idx = IDX_W'(exp_idx);
    end else if (comb_sel[RG_DRAM]) begin
      comb_hit = dram_found;
      if (dram_found) comb_idx = IDX_W'(dram_idx);
    end else if (comb_sel[RG_SIO]) begin
      if (sio_eight) begin
        comb_hit = 1'b1;
        comb_idx = sio_slot;
      end else if (!sio_slot[2]) begin
        comb_hit = 1'b1;
        comb_idx = {1'b0, sio_slot[1:0]};
      end
    end else if (comb_sel[RG_CARD]) begin
      comb_hit = 1'b1;
      comb_idx = {1'b0, addr[27:26]};
    end else if (comb_sel[RG_CSR]) begin
      if (csr_in_win) begin
        comb_hit = 1'b1;
        comb_idx = {1'b0, addr[CSR_WIN_LG-1 -: 2]};
      end
    end
  end

  if (REG_OUT != 0) begin : g_reg_out
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        region_sel <= '0;
        bank_idx   <= '0;
        hit        <= 1'b0;
      end else begin
        region_sel <= comb_sel;
        bank_idx   <= comb_idx;
        hit        <= comb_hit;
      end
    end
  end else begin : g_comb_out
    assign region_sel = comb_sel;
    assign bank_idx   = comb_idx;
    assign hit        = comb_hit;
  end
endmodule

// File: rtl/addrdec_chk.sv
module addrdec_chk #(
  parameter int N_DRAM = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [5:0]              dram_field,
  input logic [2:0]              sio_slot,
  input logic [7:0]              comb_sel,
  input logic [7:0]              raw_match,
  input logic                    comb_hit,
  input logic [2:0]              comb_idx,
  input logic                    sio_eight,
  input logic [N_DRAM-1:0][5:0]  dram_lo,
  input logic [N_DRAM-1:0][5:0]  dram_hi
);
  localparam int DI_W = (N_DRAM > 1) ? $clog2(N_DRAM) : 1;

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(comb_sel));

  a_r1_sel_from_match: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_match != 8'd0) |-> ((comb_sel & raw_match) == comb_sel) && (comb_sel != 8'd0));

  a_r9_hit_needs_region: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_sel == 8'd0) |-> (!comb_hit && comb_idx == 3'd0));

  a_r3_dram_bank_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_hit && comb_sel[4]) |->
      ((dram_field >= dram_lo[comb_idx[DI_W-1:0]]) && (dram_field <= dram_hi[comb_idx[DI_W-1:0]])));

  a_r6_sio_four_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_sel[5] && !sio_eight && sio_slot[2]) |-> !comb_hit);
endmodule

bind twostage_addr_decoder addrdec_chk #(.N_DRAM(N_DRAM)) u_chk (
  .clk(clk), .rst_n(rst_n), .dram_field(addr[25:20]), .sio_slot(sio_slot),
  .comb_sel(comb_sel), .raw_match(raw_match), .comb_hit(comb_hit), .comb_idx(comb_idx),
  .sio_eight(sio_eight), .dram_lo(dram_lo), .dram_hi(dram_hi)
);

// File: tb/sim_twostage_addr_decoder.sv
`timescale 1ns/1ps
module sim_twostage_addr_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  region_sel;
  logic [2:0]  bank_idx;
  logic        hit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // shadow of programmed values
  bit        m_en[8];
  bit [6:0]  m_base[8];
  int        m_dlo[4], m_dhi[4], m_elo[4], m_ehi[4];
  bit        m_eight;

  always #2.5 clk = ~clk;

  twostage_addr_decoder u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .region_sel(region_sel), .bank_idx(bank_idx), .hit(hit)
  );

  function automatic longint unsigned win_size(int r);
    if (r < 4) return 64'd1 << 25;
    if (r == 6) return 64'd1 << 28;
    if (r == 7) return 64'd1 << 26;
    return 64'd1 << 27;
  endfunction

  task automatic model(input logic [31:0] a, output logic [7:0] s, output logic h,
                       output logic [2:0] ix);
    int reg_hit = -1;
    longint unsigned la = a;
    longint unsigned off;
    int f;
    s = '0; h = 1'b0; ix = '0;
    for (int r = 0; r < 8; r++) begin
      longint unsigned st = longint'(m_base[r]) * (64'd1 << 25);
      if (reg_hit < 0 && m_en[r] && (la / win_size(r)) == (st / win_size(r))) reg_hit = r;
    end
    if (reg_hit < 0) return;
    s[reg_hit] = 1'b1;
    off = la % win_size(reg_hit);
    if (reg_hit < 4) begin
      f = int'((la >> 21) % 16);
      for (int b = 3; b >= 0; b--) if (f >= m_elo[b] && f <= m_ehi[b]) begin h = 1; ix = 3'(b); end
    end else if (reg_hit == 4) begin
      f = int'((la >> 20) % 64);
      for (int b = 3; b >= 0; b--) if (f >= m_dlo[b] && f <= m_dhi[b]) begin h = 1; ix = 3'(b); end
    end else if (reg_hit == 5) begin
      f = int'(off / (64'd1 << 24));
      if (m_eight || f < 4) begin h = 1; ix = 3'(f); end
    end else if (reg_hit == 6) begin
      h = 1; ix = 3'(off / (64'd1 << 26));
    end else begin
      if (off < 4096) begin h = 1; ix = 3'(off / 1024); end
    end
  endtask

  task automatic wr(input int idx, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (idx < 8) begin m_en[idx] = d[7]; m_base[idx] = d[6:0]; end
    else if (idx < 12) begin m_dlo[idx-8] = int'(d[5:0]); m_dhi[idx-8] = int'(d[13:8]); end
    else if (idx < 16) begin m_elo[idx-12] = int'(d[3:0]); m_ehi[idx-12] = int'(d[11:8]); end
    else if (idx == 16) m_eight = d[0];
  endtask

  task automatic probe(input logic [31:0] a, input string tag);
    logic [7:0] es; logic eh; logic [2:0] ei;
    addr = a;
    model(a, es, eh, ei);
    @(negedge clk);
    checks++;
    if (region_sel !== es || hit !== eh || bank_idx !== ei) begin
      errors++;
      $display("FAIL %s addr=%h sel %h exp %h hit %b exp %b idx %0d exp %0d",
               tag, a, region_sel, es, hit, eh, bank_idx, ei);
    end
  endtask

  task automatic expect_out(input string tag, input logic [7:0] es, input logic eh,
                            input logic [2:0] ei);
    checks++;
    if (region_sel !== es || hit !== eh || bank_idx !== ei) begin
      errors++;
      $display("FAIL %s sel %h exp %h hit %b exp %b idx %0d exp %0d",
               tag, region_sel, es, hit, eh, bank_idx, ei);
    end
  endtask

  task automatic std_map();
    wr(0, 16'h0080); wr(1, 16'h0081); wr(2, 16'h0082); wr(3, 16'h0083);
    wr(4, 16'h0084); wr(5, 16'h0088); wr(6, 16'h0090); wr(7, 16'h008C);
    wr(8, {2'b0, 6'd3, 2'b0, 6'd0});
    wr(9, {2'b0, 6'd4, 2'b0, 6'd4});
    wr(10, {2'b0, 6'd20, 2'b0, 6'd5});
    wr(11, {2'b0, 6'd10, 2'b0, 6'd2});
    wr(12, {4'b0, 4'd0, 4'b0, 4'd0});
    wr(13, {4'b0, 4'd3, 4'b0, 4'd1});
    wr(14, {4'b0, 4'd15, 4'b0, 4'd4});
    wr(15, {4'b0, 4'd15, 4'b0, 4'd0});
    wr(16, 16'h0000);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin m_en[i] = 0; m_base[i] = 0; end
    for (int i = 0; i < 4; i++) begin m_dlo[i] = 63; m_dhi[i] = 0; m_elo[i] = 15; m_ehi[i] = 0; end
    m_eight = 0;
    void'($urandom(32'd1234));
    addr = 32'h0840_0000;
    repeat (3) @(negedge clk);
    expect_out("R11 reset", 8'h00, 1'b0, 3'd0);
    rst_n = 1'b1;
    probe(32'h0000_0000, "R2 disabled after reset");
    probe(32'h0840_0000, "R9 unmapped after reset");

    std_map();
    probe(32'h0000_0000, "R4 exp bank0");
    probe(32'h0060_0000, "R4 exp bank1");
    probe(32'h07E0_0000, "R4 exp bank2 top");
    probe(32'h0800_0000, "R3 dram bank0 low edge");
    probe(32'h0830_0000, "R3 dram bank0 high edge");
    probe(32'h0840_0000, "R3 dram single slot bank1");
    probe(32'h0850_0000, "R3 dram overlap lowest wins");
    probe(32'h0940_0000, "R3 dram bank2 top");
    probe(32'h0A80_0000, "R10 dram no bank");
    probe(32'h1000_0000, "R6 sio slot0");
    probe(32'h1300_0000, "R6 sio slot3");
    probe(32'h1400_0000, "R6 sio upper half no hit");
    probe(32'h2000_0000, "R5 card A mem");
    probe(32'h2400_0000, "R5 card A io");
    probe(32'h2800_0000, "R5 card B mem");
    probe(32'h2FFF_FFFC, "R5 card B io");
    probe(32'h1800_0C00, "R8 csr group3");
    probe(32'h1800_1000, "R8 csr past window");
    probe(32'h3000_0000, "R9 above map");
    probe(32'hF000_0000, "R9 far away");

    wr(16, 16'h0001);
    probe(32'h1400_0000, "R7 eight mode slot4");
    probe(32'h17FF_FFFF, "R7 eight mode slot7");
    wr(16, 16'h0000);

    wr(20, 16'hFFFF);
    wr(31, 16'hFFFF);
    probe(32'h0840_0000, "R12 ignored write dram");
    probe(32'h1400_0000, "R12 ignored write sio");
    probe(32'h3000_0000, "R12 ignored write unmapped");

    wr(7, 16'h0084);
    probe(32'h0800_0000, "R1 overlap lowest region");
    wr(4, 16'h0004);
    probe(32'h0800_0000, "R1 overlap after disable");
    probe(32'h0800_1000, "R8 overlapped csr edge");
    std_map();

    addr = 32'h2400_0000;
    @(negedge clk);
    addr = 32'h0840_0000;
    #1;
    expect_out("R11 latency old value", 8'h40, 1'b1, 3'd1);
    @(negedge clk);
    expect_out("R11 latency new value", 8'h10, 1'b1, 3'd1);

    for (int it = 0; it < 4000; it++) begin
      int r = int'($urandom % 10);
      logic [31:0] a;
      if ((it % 400) == 399) begin
        int q = int'($urandom % 9);
        if (q < 4) wr(8 + q, 16'($urandom));
        else if (q < 8) wr(8 + q, 16'($urandom));
        else wr(16, 16'($urandom % 2));
      end
      if (r < 8) begin
        longint unsigned st = longint'(m_base[r]) * (64'd1 << 25);
        a = 32'(st + ($urandom % win_size(r)));
      end else a = $urandom;
      probe(a, "R1 R3 R4 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule